// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers single-cycle event pulses from several line ports into sticky status registers, one register per port, and turns them into one active-low interrupt request. Each status bit is set by its event and stays set until software reads the register that holds it. That read returns the collected bits and clears them in the same access. An event that arrives while the read is in progress is kept for the next read.

Two master control bits and a per-bit enable vector decide which pending bits may pull the interrupt low. A global enable gates the whole output. A narrowing mode lets only the three receive-cell error sources of each port raise the interrupt: header-check failure, a truncated cell and a line symbol error. The status bits still record every event, whatever the enables say. The interrupt output is a flop, so it cannot glitch, and it follows the status that is being written into the registers in that same cycle.

Detecting the cell errors is not part of this block. It only sees the pulses.

Top module: `irq_status_ctrl`

## Requirements
- R1: While master control bit 0 is 0 during a cycle, irq_n_o is 1 after the next clock edge, whatever status is pending.
- R2: With master bit 0 = 1 and bit 5 = 0, irq_n_o is 0 after the clock edge that samples an event pulse whose enable bit in src_enable_i is 1. An event whose enable bit is 0 leaves irq_n_o at 1.
- R3: With master bits 0 and 5 both = 1, only status bits 0, 1 and 2 of each port can drive irq_n_o low: bit 0 is the header-check failure, bit 1 the short cell and bit 2 the symbol error. Bits 3 to 7 are ignored for the interrupt, and clearing bit 5 again lets them assert it.
- R4: A pulse on event_pulse_i[p*8+b] sets bit b of the status register at address p. The bit stays set until that register is read, and it is recorded even when its enable bit is 0.
- R5: A read (rd_en_i = 1, rd_addr_i = p < 4) puts the register's contents on rd_data_o after the next edge and clears every bit of that register. rd_data_o holds its value until the next read.
- R6: An event that arrives in the same cycle as the clearing read of its register is left set afterwards, and it is not part of the data that read returns.
- R7: After a read, irq_n_o goes back to 1 only if no other pending bit in any register is still enabled for the interrupt.
- R8: A read at an address of 4 or more returns 0 and clears no register.
- R9: After reset every status bit is 0, irq_n_o is 1 and rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| event_pulse_i | input | 32 | Event pulses, bit p*8+b is source b of port p |
| master_ctrl_i | input | 8 | Master control; bit 0 is the global enable, bit 5 selects cell-error-only mode |
| src_enable_i | input | 32 | Per-source interrupt enables, 1 lets the source assert the interrupt |
| rd_en_i | input | 1 | Status read strobe |
| rd_addr_i | input | 3 | Status register address (port number) |
| rd_data_o | output | 8 | Data from the last status read |
| irq_n_o | output | 1 | Registered interrupt request, active low |

## Verification
On every cycle, assertions check the following:
- the interrupt stays released after a cycle with the global enable off;
- the interrupt stays released in cell-error-only mode while no cell-error bit is pending;
- set bits persist until a read;
- a read leaves exactly the events of that cycle behind;
- out-of-range reads return zero.

Only the bench scenarios can show the rest. It sweeps every port, source bit, enable value and mode, and compares each result with a software model. That covers the one-cycle timing of the interrupt, the exact data a read returns, and the interaction between ports that keeps the interrupt asserted while another enabled bit is still pending.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int MC_GLOBAL_EN_BIT = 0;
    localparam int MC_CELL_ONLY_BIT = 5;
    localparam int CELL_ERR_SRCS    = 3;
endpackage

// File: rtl/sticky_status_reg.sv
module sticky_status_reg #(
    parameter int SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] event_i,
    input  logic             clr_i,
    output logic [SRC_W-1:0] status_o,
    output logic [SRC_W-1:0] status_next_o
);
    typedef struct packed {
        logic [SRC_W-1:0] bits;
    } reg_state_t;

    reg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.bits = '0;
        end
        s_d.bits = s_d.bits | event_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o      = s_q.bits;
    assign status_next_o = s_d.bits;

    // R4: without a clear, a bit that was set stays set
    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> (($past(s_q.bits) & ~s_q.bits) == '0));

    // R4: every pulsed event is present after the edge
    assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> (($past(event_i) & ~s_q.bits) == '0));

    // R5 / R6: after a clearing read, only the events of that cycle remain
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.bits == $past(event_i)));
endmodule

// File: rtl/status_read_port.sv
module status_read_port #(
    parameter int NUM_PORTS = 4,
    parameter int SRC_W     = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    input  logic [NUM_PORTS*SRC_W-1:0] status_i,
    output logic [NUM_PORTS-1:0]       clr_o,
    output logic [SRC_W-1:0]           rd_data_o
);
    typedef struct packed {
        logic [SRC_W-1:0] data;
    } rd_state_t;

    rd_state_t r_d, r_q;
    logic      in_range;

    always_comb begin
        r_d      = r_q;
        in_range = (int'(rd_addr_i) < NUM_PORTS);
        clr_o    = '0;
        if (rd_en_i) begin
            r_d.data = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (rd_addr_i == ADDR_W'(p)) begin
                    clr_o[p] = 1'b1;
                    r_d.data = status_i[p*SRC_W +: SRC_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data_o = r_q.data;

    // R8: an address past the last register reads as zero
    assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !in_range) |=> (rd_data_o == '0));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int NUM_PORTS   = 4,
    parameter int SRC_W       = 8,
    parameter int CELL_ERR_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*SRC_W-1:0] status_next_i,
    input  logic [NUM_PORTS*SRC_W-1:0] src_enable_i,
    input  logic                       global_en_i,
    input  logic                       cell_only_i,
    output logic                       irq_n_o
);
    localparam int TOT_W = NUM_PORTS * SRC_W;

    typedef struct packed {
        logic irq_n;
    } gate_state_t;

    gate_state_t     g_d, g_q;
    logic [TOT_W-1:0] cell_bits;
    logic [TOT_W-1:0] filt;
    logic             pending;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int b = 0; b < SRC_W; b++) begin
                cell_bits[p*SRC_W+b] = (b < CELL_ERR_W);
            end
        end
        filt    = cell_only_i ? cell_bits : {TOT_W{1'b1}};
        pending = |(status_next_i & src_enable_i & filt);
        g_d       = g_q;
        g_d.irq_n = !(global_en_i && pending);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{irq_n: 1'b1};
        end else begin
            g_q <= g_d;
        end
    end

    assign irq_n_o = g_q.irq_n;

    // R1: global enable off keeps the request released
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!global_en_i) |=> irq_n_o);

    // R3: in cell-error-only mode, no pending cell error means no request
    assert_cell_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_only_i && ((status_next_i & cell_bits) == '0)) |=> irq_n_o);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int SRC_W     = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*SRC_W-1:0] event_pulse_i,
    input  logic [7:0]                 master_ctrl_i,
    input  logic [NUM_PORTS*SRC_W-1:0] src_enable_i,
    input  logic                       rd_en_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [SRC_W-1:0]           rd_data_o,
    output logic                       irq_n_o
);
    localparam int TOT_W = NUM_PORTS * SRC_W;

    logic [TOT_W-1:0]     status_q_all;
    logic [TOT_W-1:0]     status_d_all;
    logic [NUM_PORTS-1:0] clr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sticky_status_reg #(.SRC_W(SRC_W)) u_stat (
            .clk           (clk),
            .rst_n         (rst_n),
            .event_i       (event_pulse_i[p*SRC_W +: SRC_W]),
            .clr_i         (clr[p]),
            .status_o      (status_q_all[p*SRC_W +: SRC_W]),
            .status_next_o (status_d_all[p*SRC_W +: SRC_W])
        );
    end

    status_read_port #(
        .NUM_PORTS (NUM_PORTS),
        .SRC_W     (SRC_W),
        .ADDR_W    (ADDR_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .status_i  (status_q_all),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    irq_gate #(
        .NUM_PORTS  (NUM_PORTS),
        .SRC_W      (SRC_W),
        .CELL_ERR_W (CELL_ERR_SRCS)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .status_next_i (status_d_all),
        .src_enable_i  (src_enable_i),
        .global_en_i   (master_ctrl_i[MC_GLOBAL_EN_BIT]),
        .cell_only_i   (master_ctrl_i[MC_CELL_ONLY_BIT]),
        .irq_n_o       (irq_n_o)
    );
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
    localparam int NP = 4;
    localparam int SW = 8;
    localparam int AW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP*SW-1:0] ev = '0;
    logic [7:0]     mc = '0;
    logic [NP*SW-1:0] en = '0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  rd_addr = '0;
    logic [SW-1:0]  rd_data;
    logic           irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irq_status_ctrl #(.NUM_PORTS(NP), .SRC_W(SW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .event_pulse_i(ev), .master_ctrl_i(mc),
        .src_enable_i(en), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_n_o(irq_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input int addr);
        rd_en   = 1'b1;
        rd_addr = AW'(addr);
        tick();
        rd_en   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(irq_n == 1'b1, "R9 irq after reset", int'(irq_n), 1);
        check(rd_data == '0, "R9 rd_data after reset", int'(rd_data), 0);
        for (int p = 0; p < NP; p++) begin
            do_read(p);
            check(rd_data == '0, "R9 status after reset", int'(rd_data), 0);
        end

        // Sweep: global enable x cell-only x enable bit x port x source (R1 R2 R3 R4 R5 R7)
        for (int g = 0; g < 2; g++) begin
            for (int c = 0; c < 2; c++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int p = 0; p < NP; p++) begin
                        for (int b = 0; b < SW; b++) begin
                            string tag;
                            bit    exp_irq;
                            mc = 8'h00;
                            mc[0] = g[0];
                            mc[5] = c[0];
                            en = '1;
                            en[p*SW+b] = m[0];
                            exp_irq = g[0] && m[0] && (!c[0] || b < 3);
                            tag = (g == 0) ? "R1" : ((c == 1 && b >= 3) ? "R3" : "R2");
                            ev = '0;
                            ev[p*SW+b] = 1'b1;
                            tick();
                            ev = '0;
                            check(irq_n == !exp_irq, tag, int'(irq_n), int'(!exp_irq));
                            do_read(p);
                            check(rd_data == SW'(1 << b), "R4 captured bit", int'(rd_data), 1 << b);
                            check(irq_n == 1'b1, "R7 release after read", int'(irq_n), 1);
                            do_read(p);
                            check(rd_data == '0, "R5 cleared by read", int'(rd_data), 0);
                        end
                    end
                end
            end
        end

        mc = 8'h01;
        en = '1;

        // R6: event in the same cycle as the clearing read
        ev = '0; ev[2*SW+1] = 1'b1; tick();
        ev = '0; ev[2*SW+6] = 1'b1;
        rd_en = 1'b1; rd_addr = 3'd2; tick();
        rd_en = 1'b0; ev = '0;
        check(rd_data == 8'h02, "R6 read excludes new event", int'(rd_data), 8'h02);
        check(irq_n == 1'b0, "R6 new event keeps irq", int'(irq_n), 0);
        do_read(2);
        check(rd_data == 8'h40, "R6 new event retained", int'(rd_data), 8'h40);
        check(irq_n == 1'b1, "R7 released after second read", int'(irq_n), 1);

        // R7: another enabled bit elsewhere keeps irq low
        ev = '0; ev[0*SW+3] = 1'b1; ev[1*SW+4] = 1'b1; tick(); ev = '0;
        do_read(0);
        check(rd_data == 8'h08, "R5 port0 data", int'(rd_data), 8'h08);
        check(irq_n == 1'b0, "R7 other port still pending", int'(irq_n), 0);
        do_read(1);
        check(irq_n == 1'b1, "R7 all cleared", int'(irq_n), 1);

        // R7: remaining bit is disabled, so irq releases; R4 masked bit still recorded
        en[3*SW+5] = 1'b0;
        ev = '0; ev[0*SW+3] = 1'b1; ev[3*SW+5] = 1'b1; tick(); ev = '0;
        do_read(0);
        check(irq_n == 1'b1, "R7 only disabled bit left", int'(irq_n), 1);
        do_read(3);
        check(rd_data == 8'h20, "R4 disabled bit recorded", int'(rd_data), 8'h20);
        en = '1;

        // R8: out-of-range reads return zero and clear nothing
        ev = '0; ev[1*SW+0] = 1'b1; tick(); ev = '0;
        for (int a = NP; a < (1 << AW); a++) begin
            do_read(a);
            check(rd_data == '0, "R8 out-of-range data", int'(rd_data), 0);
            check(irq_n == 1'b0, "R8 nothing cleared", int'(irq_n), 0);
        end
        do_read(1);
        check(rd_data == 8'h01, "R8 status preserved", int'(rd_data), 8'h01);

        // R3: live switch of cell-only mode with a non-cell bit pending
        ev = '0; ev[0*SW+4] = 1'b1; tick(); ev = '0;
        check(irq_n == 1'b0, "R2 non-cell bit asserts", int'(irq_n), 0);
        mc = 8'h21; tick();
        check(irq_n == 1'b1, "R3 non-cell bit suppressed", int'(irq_n), 1);
        mc = 8'h01; tick();
        check(irq_n == 1'b0, "R3 mode cleared re-asserts", int'(irq_n), 0);
        mc = 8'h00; tick();
        check(irq_n == 1'b1, "R1 global enable off", int'(irq_n), 1);
        mc = 8'h01;
        do_read(0);
        check(rd_data == 8'h10, "R4 bit held across mode changes", int'(rd_data), 8'h10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule